// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

This unit watches the instruction-fetch stream and decides, for each fetched instruction, whether a hardware breakpoint or a software breakpoint instruction should raise a debug event. It holds four breakpoint pairs. Each pair has a value register and a control register. A pair can compare the fetch address on its own, compare the fetch address while qualified by a context-ID pair, or compare the current context ID on its own. Only pairs 2 and 3 can act as context-ID holders.

All match conditions are evaluated in the cycle of the fetch. The results travel in a small tag alongside the instruction through a fixed-depth pipeline model. A flush empties that pipeline. An event pulse with a cause code appears only when the instruction at the end of the pipeline is committed. The event does not depend on the instruction's condition-code outcome.

Top module: `bkpt_match_unit`

## Requirements
- R1: A pair whose control register has enable (bit 0) set and mode (bits 2:1) equal to 0 matches when `fetchAddr` equals its value register. Such a match is reported with cause 1 (address).
- R2: The privilege select (bits 4:3) gates every match of its pair. Bit 3 allows user fetches (`fetchPriv`=0) and bit 4 allows privileged fetches (`fetchPriv`=1).
- R3: With mode 1 (linked address), an address match also requires the pair named by the link field (bits 6:5) to be context-capable (index 2 or 3), to be enabled, and to hold a value equal to `curCtxId` at fetch. Otherwise there is no match.
- R4: With mode 2 (context ID), a pair with index 2 or 3 matches when `curCtxId` equals its value, and this is reported with cause 2. Pairs 0 and 1 in mode 2 never match.
- R5: Match conditions are sampled in the fetch cycle. Later changes to `curCtxId`, to the privilege input or to the breakpoint registers do not alter the event of an instruction already fetched.
- R6: A fetched instruction reaches the last of 3 tag stages after 3 clock edges. Asserting `commit` in that cycle raises `dbgEvent` for exactly one cycle after the next edge. An instruction that is not committed there is dropped and produces no event.
- R7: `flush` discards every tag in flight, including a fetch or commit presented in the same cycle. None of the discarded instructions ever produces an event.
- R8: A fetch marked by `fetchIsBkpt` produces cause 3 (software) whenever it commits, independent of the registers. The cause priority is software, then address, then context ID.
- R9: A pair with enable clear, or with mode 3, never matches on its own. A mode-3 pair that is enabled still serves as a link qualifier.
- R10: Reset clears all value and control registers and the tag pipeline, and drives `dbgEvent` low and `dbgCause` to 0. While `dbgEvent` is low, `dbgCause` is 0.
- R11: A write with `regWrEn` high loads the pair selected by `regWrSel`. `regWrCtl`=1 selects the control register and 0 selects the value register. The write takes effect for fetches in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrCtl | input | 1 | 1 writes the control register, 0 writes the value register |
| regWrSel | input | 2 | Pair index for the write |
| regWrData | input | 32 | Write data |
| fetchValid | input | 1 | A fetch is presented this cycle |
| fetchAddr | input | 32 | Instruction-side virtual address of the fetch |
| fetchPriv | input | 1 | 1 for a privileged fetch, 0 for user |
| fetchIsBkpt | input | 1 | The fetched instruction is a software breakpoint |
| curCtxId | input | 32 | Current context ID |
| flush | input | 1 | Discard all instructions in flight |
| commit | input | 1 | The instruction in the last tag stage commits |
| dbgEvent | output | 1 | One-cycle debug event pulse |
| dbgCause | output | 2 | 0 none, 1 address, 2 context ID, 3 software |

## Verification
The bench targets linked address pairs whose qualifier is disabled, not context-capable or holding a different ID. A design that ignored any of these would raise address events for the wrong process. It also changes the context ID and the registers while an instruction is in flight. A design that matched at commit instead of at fetch would report or lose events there. Flushes that coincide with fetch or commit, uncommitted tags and back-to-back commits are exercised as well: pipeline slips show up as events that are missing, repeated or assigned the wrong cause. The cause priority and the behaviour of a pair in context mode at index 0 are checked directly.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    MODE_ADDR        = 2'd0,
    MODE_ADDR_LINKED = 2'd1,
    MODE_CTX         = 2'd2,
    MODE_RSVD        = 2'd3
  } bpMode_e;

  // control register layout: [6:5] link pair, [4:3] privilege select, [2:1] mode, [0] enable
  typedef struct packed {
    logic [1:0] linkSel;
    logic [1:0] privSel;
    bpMode_e    mode;
    logic       enable;
  } bpCtl_t;

  localparam int CTL_W = $bits(bpCtl_t);

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ADDR = 2'd1,
    CAUSE_CTX  = 2'd2,
    CAUSE_SW   = 2'd3
  } evCause_e;

  typedef struct packed {
    logic valid;
    logic swBkpt;
    logic addrHit;
    logic ctxHit;
  } fetchTag_t;

  typedef struct packed {
    logic valWe;
    logic ctlWe;
    logic capture;
    logic squash;
    logic retire;
  } bpStrobes_t;

endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic       regWrEn,
  input  logic       regWrCtl,
  input  logic       fetchValid,
  input  logic       flush,
  input  logic       commit,
  output bpStrobes_t strobes
);

  // flush overrides both a new fetch and a retirement in the same cycle
  always_comb begin
    strobes.valWe   = regWrEn & ~regWrCtl;
    strobes.ctlWe   = regWrEn & regWrCtl;
    strobes.capture = fetchValid & ~flush;
    strobes.squash  = flush;
    strobes.retire  = commit & ~flush;
  end

endmodule

// File: rtl/bkpt_datapath.sv
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS  = 4,
  parameter int DATA_W     = 32,
  parameter int CTX_FIRST  = 2,
  parameter int PIPE_DEPTH = 3,
  parameter int SEL_W      = $clog2(NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobes_t        strobes,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] fetchAddr,
  input  logic              fetchPriv,
  input  logic              fetchIsBkpt,
  input  logic [DATA_W-1:0] curCtxId,
  output logic              dbgEvent,
  output logic [1:0]        dbgCause
);

  localparam int LAST = PIPE_DEPTH - 1;

  logic [DATA_W-1:0] valReg [NUM_PAIRS];
  bpCtl_t            ctlReg [NUM_PAIRS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        valReg[i] <= '0;
        ctlReg[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        if (strobes.valWe && regWrSel == SEL_W'(i)) valReg[i] <= regWrData;
        if (strobes.ctlWe && regWrSel == SEL_W'(i)) ctlReg[i] <= bpCtl_t'(regWrData[CTL_W-1:0]);
      end
    end
  end

  logic [NUM_PAIRS-1:0] ctxEq;
  logic [NUM_PAIRS-1:0] addrHitVec;
  logic [NUM_PAIRS-1:0] ctxHitVec;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : gPair
    logic privOk;
    logic linkOk;
    logic addrEq;

    if (g >= CTX_FIRST) begin : gCtxCapable
      assign ctxEq[g] = ctlReg[g].enable && (valReg[g] == curCtxId);
    end else begin : gAddrOnly
      assign ctxEq[g] = 1'b0;
    end

    assign privOk = fetchPriv ? ctlReg[g].privSel[1] : ctlReg[g].privSel[0];
    assign addrEq = (valReg[g] == fetchAddr);
    assign linkOk = (int'(ctlReg[g].linkSel) < NUM_PAIRS) ? ctxEq[ctlReg[g].linkSel] : 1'b0;

    assign addrHitVec[g] = ctlReg[g].enable && privOk && addrEq &&
                           ((ctlReg[g].mode == MODE_ADDR) ||
                            (ctlReg[g].mode == MODE_ADDR_LINKED && linkOk));
    assign ctxHitVec[g]  = ctlReg[g].enable && privOk &&
                           (ctlReg[g].mode == MODE_CTX) && ctxEq[g];
  end

  fetchTag_t newTag;
  fetchTag_t tagPipe [PIPE_DEPTH];

  always_comb begin
    newTag.valid   = 1'b1;
    newTag.swBkpt  = fetchIsBkpt;
    newTag.addrHit = |addrHitVec;
    newTag.ctxHit  = |ctxHitVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.squash) begin
      for (int k = 0; k < PIPE_DEPTH; k++) tagPipe[k] <= '0;
    end else begin
      tagPipe[0] <= strobes.capture ? newTag : '0;
      for (int k = 1; k < PIPE_DEPTH; k++) tagPipe[k] <= tagPipe[k-1];
    end
  end

  fetchTag_t retTag;
  logic      fireNext;
  evCause_e  causeNext;

  always_comb begin
    retTag   = tagPipe[LAST];
    fireNext = strobes.retire && retTag.valid &&
               (retTag.swBkpt || retTag.addrHit || retTag.ctxHit);
    if (!fireNext)          causeNext = CAUSE_NONE;
    else if (retTag.swBkpt) causeNext = CAUSE_SW;
    else if (retTag.addrHit) causeNext = CAUSE_ADDR;
    else                    causeNext = CAUSE_CTX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgEvent <= 1'b0;
      dbgCause <= 2'd0;
    end else begin
      dbgEvent <= fireNext;
      dbgCause <= causeNext;
    end
  end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS  = 4,
  parameter int DATA_W     = 32,
  parameter int CTX_FIRST  = 2,
  parameter int PIPE_DEPTH = 3,
  localparam int SEL_W     = $clog2(NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrCtl,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchAddr,
  input  logic              fetchPriv,
  input  logic              fetchIsBkpt,
  input  logic [DATA_W-1:0] curCtxId,
  input  logic              flush,
  input  logic              commit,
  output logic              dbgEvent,
  output logic [1:0]        dbgCause
);

  bpStrobes_t strobes;

  bkpt_ctrl uCtrl (
    .regWrEn   (regWrEn),
    .regWrCtl  (regWrCtl),
    .fetchValid(fetchValid),
    .flush     (flush),
    .commit    (commit),
    .strobes   (strobes)
  );

  bkpt_datapath #(
    .NUM_PAIRS (NUM_PAIRS),
    .DATA_W    (DATA_W),
    .CTX_FIRST (CTX_FIRST),
    .PIPE_DEPTH(PIPE_DEPTH),
    .SEL_W     (SEL_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWrSel   (regWrSel),
    .regWrData  (regWrData),
    .fetchAddr  (fetchAddr),
    .fetchPriv  (fetchPriv),
    .fetchIsBkpt(fetchIsBkpt),
    .curCtxId   (curCtxId),
    .dbgEvent   (dbgEvent),
    .dbgCause   (dbgCause)
  );

endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       flush,
  input logic       commit,
  input logic       dbgEvent,
  input logic [1:0] dbgCause
);

  assert_cause_on_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    dbgEvent |-> (dbgCause != 2'd0));

  assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEvent |-> (dbgCause == 2'd0));

  assert_event_needs_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    dbgEvent |-> $past(commit));

  assert_flush_blocks_retire_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |-> !dbgEvent);

  assert_flush_drains_pipe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush, 2) |-> !dbgEvent);

endmodule

bind bkpt_match_unit bkpt_match_unit_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .flush   (flush),
  .commit  (commit),
  .dbgEvent(dbgEvent),
  .dbgCause(dbgCause)
);

// File: tb/tb_bkpt_match_unit.sv
`timescale 1ns/1ps
module tb_bkpt_match_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regWrCtl = 1'b0;
  logic [1:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic        fetchValid = 1'b0, fetchPriv = 1'b0, fetchIsBkpt = 1'b0;
  logic [31:0] fetchAddr = '0, curCtxId = '0;
  logic        flush = 1'b0, commit = 1'b0;
  logic        dbgEvent;
  logic [1:0]  dbgCause;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  bkpt_match_unit dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrCtl(regWrCtl),
    .regWrSel(regWrSel), .regWrData(regWrData), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .fetchPriv(fetchPriv), .fetchIsBkpt(fetchIsBkpt),
    .curCtxId(curCtxId), .flush(flush), .commit(commit),
    .dbgEvent(dbgEvent), .dbgCause(dbgCause)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        priv;
    logic [31:0] ctx;
    logic        bk;
    logic [1:0]  cause;
  } vec_t;

  // pair0: 0x1000 address, privileged only; pair1: 0x2000 linked to pair3;
  // pair2: context 0x55; pair3: value 0x77, mode 3 (qualifier only)
  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000, 1'b1, 32'h0,  1'b0, 2'd1},
    '{32'h1000, 1'b0, 32'h0,  1'b0, 2'd0},
    '{32'h1004, 1'b1, 32'h0,  1'b0, 2'd0},
    '{32'h2000, 1'b0, 32'h77, 1'b0, 2'd1},
    '{32'h2000, 1'b0, 32'h76, 1'b0, 2'd0},
    '{32'h3000, 1'b0, 32'h55, 1'b0, 2'd2},
    '{32'h3000, 1'b0, 32'h54, 1'b0, 2'd0},
    '{32'h1000, 1'b1, 32'h55, 1'b0, 2'd1},
    '{32'h3000, 1'b0, 32'h0,  1'b1, 2'd3},
    '{32'h1000, 1'b1, 32'h55, 1'b1, 2'd3},
    '{32'h77,   1'b1, 32'h0,  1'b0, 2'd0},
    '{32'h2000, 1'b1, 32'h77, 1'b0, 2'd1}
  };

  function automatic logic [31:0] mkCtl(input logic en, input logic [1:0] mode,
                                        input logic [1:0] priv, input logic [1:0] link);
    return {25'd0, link, priv, mode, en};
  endfunction

  task automatic expectEv(input logic expEv, input logic [1:0] expCause, input string req);
    nChecks++;
    if (dbgEvent !== expEv || dbgCause !== expCause) begin
      nFails++;
      $display("FAIL %s: actual event=%0b cause=%0d expected event=%0b cause=%0d",
               req, dbgEvent, dbgCause, expEv, expCause);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic isCtl, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrCtl = isCtl; regWrSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // fetch, let the tag reach the last stage, optionally commit; returns at the
  // falling edge after the edge that registers the event
  task automatic runOne(input logic [31:0] a, input logic p, input logic [31:0] c,
                        input logic b, input logic doCommit);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a; fetchPriv = p; curCtxId = c; fetchIsBkpt = b;
    @(negedge clk);
    fetchValid = 1'b0; fetchIsBkpt = 1'b0;
    @(negedge clk);
    @(negedge clk);
    commit = doCommit;
    @(negedge clk);
    commit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectEv(1'b0, 2'd0, "R10 reset outputs");

    // R10/R9: registers cleared to zero, so an all-zero fetch must not match
    runOne(32'h0, 1'b1, 32'h0, 1'b0, 1'b1);
    expectEv(1'b0, 2'd0, "R10 cleared registers disabled");

    // R11 configuration through the write port
    writeReg(2'd0, 1'b0, 32'h1000);
    writeReg(2'd0, 1'b1, mkCtl(1'b1, 2'd0, 2'b10, 2'd0));
    writeReg(2'd1, 1'b0, 32'h2000);
    writeReg(2'd1, 1'b1, mkCtl(1'b1, 2'd1, 2'b11, 2'd3));
    writeReg(2'd2, 1'b0, 32'h55);
    writeReg(2'd2, 1'b1, mkCtl(1'b1, 2'd2, 2'b11, 2'd0));
    writeReg(2'd3, 1'b0, 32'h77);
    writeReg(2'd3, 1'b1, mkCtl(1'b1, 2'd3, 2'b11, 2'd0));

    // vector table: R1 R2 R3 R4 R8 R9 R11
    for (int i = 0; i < NVEC; i++) begin
      runOne(VECS[i].addr, VECS[i].priv, VECS[i].ctx, VECS[i].bk, 1'b1);
      expectEv(VECS[i].cause != 2'd0, VECS[i].cause, $sformatf("R1-table vector %0d", i));
      @(negedge clk);
      expectEv(1'b0, 2'd0, $sformatf("R6 single pulse after vector %0d", i));
    end

    // R6: no commit drops the instruction; a later commit finds nothing
    runOne(32'h1000, 1'b1, 32'h0, 1'b0, 1'b0);
    expectEv(1'b0, 2'd0, "R6 uncommitted");
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    expectEv(1'b0, 2'd0, "R6 dropped tag stays dropped");

    // R6: back-to-back commits with different causes
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h1000; fetchPriv = 1'b1; curCtxId = 32'h0;
    @(negedge clk);
    fetchAddr = 32'h3000; fetchPriv = 1'b0; curCtxId = 32'h55;
    @(negedge clk);
    fetchValid = 1'b0;
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    expectEv(1'b1, 2'd1, "R6 first of pair");
    @(negedge clk);
    commit = 1'b0;
    expectEv(1'b1, 2'd2, "R6 second of pair");

    // R7: flush while the tag is in flight
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h1000; fetchPriv = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    expectEv(1'b0, 2'd0, "R7 flushed in flight");

    // R7: flush in the same cycle as commit
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h1000; fetchPriv = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    commit = 1'b1; flush = 1'b1;
    @(negedge clk);
    commit = 1'b0; flush = 1'b0;
    expectEv(1'b0, 2'd0, "R7 flush with commit");

    // R7: flush in the same cycle as the fetch
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h1000; fetchPriv = 1'b1; flush = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0; flush = 1'b0;
    @(negedge clk);
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    expectEv(1'b0, 2'd0, "R7 flush with fetch");

    // R5: context and registers change after the fetch; event unchanged
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h3000; fetchPriv = 1'b0; curCtxId = 32'h55;
    @(negedge clk);
    fetchValid = 1'b0; curCtxId = 32'h0;
    regWrEn = 1'b1; regWrCtl = 1'b1; regWrSel = 2'd2; regWrData = 32'h0;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    expectEv(1'b1, 2'd2, "R5 sampled at fetch despite later change");

    // R5: pair enabled only after the fetch gives no event
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h3000; curCtxId = 32'h55;
    @(negedge clk);
    fetchValid = 1'b0;
    regWrEn = 1'b1; regWrCtl = 1'b1; regWrSel = 2'd2;
    regWrData = mkCtl(1'b1, 2'd2, 2'b11, 2'd0);
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    expectEv(1'b0, 2'd0, "R5 late enable ignored");
    runOne(32'h3000, 1'b0, 32'h55, 1'b0, 1'b1);
    expectEv(1'b1, 2'd2, "R11 re-enabled pair matches");

    // R4: pair 0 in context mode never matches
    writeReg(2'd0, 1'b0, 32'h99);
    writeReg(2'd0, 1'b1, mkCtl(1'b1, 2'd2, 2'b11, 2'd0));
    runOne(32'h4000, 1'b1, 32'h99, 1'b0, 1'b1);
    expectEv(1'b0, 2'd0, "R4 pair 0 not context-capable");

    // R3: link to a pair that cannot hold a context ID
    writeReg(2'd1, 1'b1, mkCtl(1'b1, 2'd1, 2'b11, 2'd0));
    runOne(32'h2000, 1'b1, 32'h99, 1'b0, 1'b1);
    expectEv(1'b0, 2'd0, "R3 link to non-capable pair");

    // R3: link qualifier disabled
    writeReg(2'd1, 1'b1, mkCtl(1'b1, 2'd1, 2'b11, 2'd3));
    writeReg(2'd3, 1'b1, mkCtl(1'b0, 2'd3, 2'b11, 2'd0));
    runOne(32'h2000, 1'b1, 32'h77, 1'b0, 1'b1);
    expectEv(1'b0, 2'd0, "R3 disabled qualifier");

    // R9: disabled address pair
    writeReg(2'd1, 1'b1, mkCtl(1'b0, 2'd0, 2'b11, 2'd0));
    runOne(32'h2000, 1'b1, 32'h0, 1'b0, 1'b1);
    expectEv(1'b0, 2'd0, "R9 disabled pair");

    // R8: software breakpoint with every pair disabled
    runOne(32'h5000, 1'b0, 32'h0, 1'b1, 1'b1);
    expectEv(1'b1, 2'd3, "R8 software breakpoint alone");

    // R10: reset in mid-run clears registers
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    expectEv(1'b0, 2'd0, "R10 outputs after reset");
    runOne(32'h3000, 1'b0, 32'h55, 1'b0, 1'b1);
    expectEv(1'b0, 2'd0, "R10 registers cleared by reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule